// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block times each cycle on an external memory bus. A cycle request carries a region tag, a direction and a flag that marks the configuration-fetch cycle. The block runs the cycle through four or five clock-wide phases. First comes the address-latch phase. Next comes the strobe phase, where the read or write strobe is driven low. Then a hold phase raises a one-clock done pulse. After some reads there is one more idle clock, the float phase, which gives a slow memory time to release the data lines before the next address goes out. Pin drivers and address multiplexing live outside the block.

Programmed wait states lengthen the strobe phase only for accesses tagged for region 1. The wait count comes from a 2-bit active-low select together with an active-low enable for extended float timing. When extended float timing is on, only one or three wait states can be chosen. The configuration-fetch cycle always uses extended float timing. When its enable is set, an active-low ready input from the memory can extend the strobe further. A separate enable drives a square wave at half the clock rate on a wait-clock output.

A controller raises `req_valid` with the request fields and holds them stable. The request is taken on the first rising edge where `req_ready` is high. After that the controller waits for `done`.

Top module: `xbus_wait_seq`

## Requirements
- R1: While reset is held and right after it: `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `done`=0, `phase`=0 and `wclk`=0.
- R2: A request accepted at a rising edge (`req_valid` and `req_ready` both high) drives `ale` high for exactly the next clock, with `phase`=1. Both strobes stay high during that clock.
- R3: In the strobe phase (`phase`=2), a read drives only `rd_n` low and a write drives only `wr_n` low. The strobe lasts 1+W clocks, where W is the wait count. The two strobes are never low together.
- R4: With `cfg_edf_n`=1 (standard float timing), a region-1 access takes W from `cfg_wsb_n` as follows: 2'b11 gives 0, 2'b10 gives 1, 2'b01 gives 2 and 2'b00 gives 3.
- R5: With `cfg_edf_n`=0 (extended float timing), a region-1 access takes W=1 for `cfg_wsb_n` 2'b11 or 2'b10, and W=3 for 2'b01 or 2'b00.
- R6: An access whose region tag is not 1 takes W=0, whatever the configuration bits.
- R7: A configuration-fetch cycle (`req_cfg_fetch`=1) is always a read and always uses extended float timing (R5 wait table and R10 float clock), even when `cfg_edf_n`=1.
- R8: With `rtw_en`=1, while `wait_n` is low at the end of the last programmed strobe clock (or a later one), the strobe phase continues. With `rtw_en`=0, `wait_n` has no effect on the strobe length.
- R9: `done` is high for exactly one clock (`phase`=3), in the clock right after the strobe phase ends. Both strobes are high during that clock.
- R10: A read with extended float timing adds one float clock (`phase`=4) after the done clock and before `req_ready` returns. Writes and standard-timing reads have no float clock.
- R11: `req_ready` is high only while idle (`phase`=0). A request raised during a cycle and dropped before the cycle ends starts no bus cycle.
- R12: While `wclk_en`=1, `wclk` toggles on every clock (half the clock frequency). While `wclk_en`=0, `wclk` is driven to 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Cycle request |
| req_region | input | REGION_W | Region tag of the request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_cfg_fetch | input | 1 | Marks the configuration-fetch cycle |
| cfg_edf_n | input | 1 | Extended float timing enable, active low |
| cfg_wsb_n | input | 2 | Region-1 wait select, active low |
| rtw_en | input | 1 | Enables the real-time wait input |
| wait_n | input | 1 | Real-time wait from memory, active low |
| wclk_en | input | 1 | Enables the wait-clock output |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| ale | output | 1 | Address-latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| phase | output | 3 | 0 idle, 1 address, 2 strobe, 3 hold, 4 float |
| done | output | 1 | One-clock end-of-cycle pulse |
| wclk | output | 1 | Wait clock, half the clock rate |

## Verification
The assertions assume that `wait_n` is already synchronous to `clk`. They also assume that the request fields and configuration bits are stable at the accepting edge, because the block latches the wait count, direction and float mode only at that edge. The stimulus changes inputs only on falling edges and keeps configuration constant from acceptance to completion. It releases `wait_n` within the strobe window whenever the real-time wait is enabled, so no cycle is held open forever. Requests raised during a busy cycle are dropped before the cycle returns to idle, so a busy-time request can never be accepted later by accident.

// File: rtl/xbus_seq_pkg.sv
package xbus_seq_pkg;

    // Phase codes; the numeric values are visible on the phase port.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_ADDR  = 3'd1,
        PH_STRB  = 3'd2,
        PH_HOLD  = 3'd3,
        PH_FLOAT = 3'd4
    } bus_phase_e;

    localparam int unsigned WSEL_W  = 2;
    localparam int unsigned PHASE_W = 3;

endpackage

// File: rtl/xbus_wait_decode.sv
module xbus_wait_decode #(
    parameter int unsigned REGION_W    = 2,
    parameter int unsigned WAIT_REGION = 1,
    parameter int unsigned CNT_W       = 2
) (
    input  logic [REGION_W-1:0]              region,
    input  logic                             ext_float,
    input  logic [xbus_seq_pkg::WSEL_W-1:0]  wsel_n,
    output logic [CNT_W-1:0]                 wait_cnt
);
    localparam logic [REGION_W-1:0] TARGET = REGION_W'(WAIT_REGION);

    logic [CNT_W-1:0] std_cnt;
    logic [CNT_W-1:0] ext_cnt;
    logic             hit;

    // Standard timing: count is the inverted select.
    // Extended timing: only the upper select bit matters (1 or 3).
    always_comb begin
        std_cnt  = CNT_W'(~wsel_n);
        ext_cnt  = wsel_n[1] ? CNT_W'(1) : CNT_W'(3);
        hit      = (region == TARGET);
        wait_cnt = '0;
        if (hit) begin
            wait_cnt = ext_float ? ext_cnt : std_cnt;
        end
    end
endmodule

// File: rtl/xbus_wclk_gen.sv
module xbus_wclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic wclk
);
    logic wclk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
        end else if (en) begin
            wclk_q <= ~wclk_q;
        end else begin
            wclk_q <= 1'b0;
        end
    end

    assign wclk = wclk_q;
endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm #(
    parameter int unsigned CNT_W = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic                               ext_float,
    input  logic [CNT_W-1:0]                   wait_cnt,
    input  logic                               rtw_en,
    input  logic                               wait_n,
    output logic                               req_ready,
    output logic                               ale,
    output logic                               rd_n,
    output logic                               wr_n,
    output logic                               done,
    output logic [xbus_seq_pkg::PHASE_W-1:0]   phase
);
    import xbus_seq_pkg::*;

    bus_phase_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wr_q;
    logic             ext_q;
    logic             accept;
    logic             stretch;

    assign accept  = (state_q == PH_IDLE) && req_valid;
    assign stretch = (cnt_q != '0) || (rtw_en && !wait_n);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE:  if (req_valid) state_d = PH_ADDR;
            PH_ADDR:  state_d = PH_STRB;
            PH_STRB:  if (!stretch) state_d = PH_HOLD;
            PH_HOLD:  state_d = (ext_q && !wr_q) ? PH_FLOAT : PH_IDLE;
            PH_FLOAT: state_d = PH_IDLE;
            default:  state_d = PH_IDLE;
        endcase
    end

    // State register and per-cycle context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            wr_q    <= 1'b0;
            ext_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= wait_cnt;
                wr_q  <= req_write;
                ext_q <= ext_float;
            end else if (state_q == PH_STRB && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Moore outputs
    always_comb begin
        req_ready = 1'b0;
        ale       = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            PH_IDLE:  req_ready = 1'b1;
            PH_ADDR:  ale = 1'b1;
            PH_STRB:  begin
                rd_n = wr_q;
                wr_n = !wr_q;
            end
            PH_HOLD:  done = 1'b1;
            PH_FLOAT: ;
            default:  ;
        endcase
        phase = state_q;
    end
endmodule

// File: rtl/xbus_wait_seq.sv
module xbus_wait_seq #(
    parameter int unsigned REGION_W    = 2,
    parameter int unsigned WAIT_REGION = 1,
    parameter int unsigned CNT_W       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [REGION_W-1:0] req_region,
    input  logic                req_write,
    input  logic                req_cfg_fetch,
    input  logic                cfg_edf_n,
    input  logic [1:0]          cfg_wsb_n,
    input  logic                rtw_en,
    input  logic                wait_n,
    input  logic                wclk_en,
    output logic                req_ready,
    output logic                ale,
    output logic                rd_n,
    output logic                wr_n,
    output logic [2:0]          phase,
    output logic                done,
    output logic                wclk
);
    logic             ext_float;
    logic             eff_write;
    logic [CNT_W-1:0] wait_cnt;

    // Configuration fetch forces extended float timing and a read.
    assign ext_float = req_cfg_fetch | ~cfg_edf_n;
    assign eff_write = req_write & ~req_cfg_fetch;

    xbus_wait_decode #(
        .REGION_W    (REGION_W),
        .WAIT_REGION (WAIT_REGION),
        .CNT_W       (CNT_W)
    ) u_decode (
        .region    (req_region),
        .ext_float (ext_float),
        .wsel_n    (cfg_wsb_n),
        .wait_cnt  (wait_cnt)
    );

    xbus_cycle_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (eff_write),
        .ext_float (ext_float),
        .wait_cnt  (wait_cnt),
        .rtw_en    (rtw_en),
        .wait_n    (wait_n),
        .req_ready (req_ready),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .done      (done),
        .phase     (phase)
    );

    xbus_wclk_gen u_wclk (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (wclk_en),
        .wclk  (wclk)
    );
endmodule

// File: rtl/xbus_wait_seq_chk.sv
module xbus_wait_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       ale,
    input logic       rd_n,
    input logic       wr_n,
    input logic       done,
    input logic [2:0] phase,
    input logic       wclk_en,
    input logic       wclk
);
    AST_ALE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (ale && phase == 3'd1)); // R2

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale); // R2

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n)); // R3

    AST_STROBE_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (phase == 3'd2 && !ale && !done)); // R3

    AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == 3'd2 && rd_n && wr_n)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_FLOAT_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) |-> $past(done)); // R10

    AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (phase == 3'd0 && !ale && rd_n && wr_n)); // R11

    AST_WCLK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wclk_en |=> (wclk != $past(wclk))); // R12

    AST_WCLK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !wclk_en |=> !wclk); // R12
endmodule

bind xbus_wait_seq xbus_wait_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .done      (done),
    .phase     (phase),
    .wclk_en   (wclk_en),
    .wclk      (wclk)
);

// File: tb/xbus_wait_seq_tb.sv
`timescale 1ns/1ps
module xbus_wait_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_region = 2'd0;
    logic       req_write = 1'b0;
    logic       req_cfg_fetch = 1'b0;
    logic       cfg_edf_n = 1'b1;
    logic [1:0] cfg_wsb_n = 2'b11;
    logic       rtw_en = 1'b0;
    logic       wait_n = 1'b1;
    logic       wclk_en = 1'b0;
    logic       req_ready, ale, rd_n, wr_n, done, wclk;
    logic [2:0] phase;

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct {
        bit    wr;
        int    slen;
        int    flt;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    xbus_wait_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_region(req_region),
        .req_write(req_write), .req_cfg_fetch(req_cfg_fetch), .cfg_edf_n(cfg_edf_n),
        .cfg_wsb_n(cfg_wsb_n), .rtw_en(rtw_en), .wait_n(wait_n), .wclk_en(wclk_en),
        .req_ready(req_ready), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .phase(phase),
        .done(done), .wclk(wclk)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Wait count from the requirements (R4, R5, R6, R7)
    function automatic int exp_wait(input logic [1:0] region, input bit cfg,
                                    input bit edfn, input logic [1:0] wsbn);
        bit ext;
        ext = cfg || !edfn;
        if (region != 2'd1) return 0;
        if (!ext) return 3 - int'(wsbn);
        return wsbn[1] ? 1 : 3;
    endfunction

    // Driver: applies one access and pushes the expected cycle shape.
    task automatic run_acc(input logic [1:0] region, input bit wr, input bit cfg,
                           input bit edfn, input logic [1:0] wsbn, input bit rtw,
                           input int stall, input bit poke, input string tag);
        exp_t e;
        int   w;
        int   n;
        @(negedge clk);
        req_region    = region;
        req_write     = wr;
        req_cfg_fetch = cfg;
        cfg_edf_n     = edfn;
        cfg_wsb_n     = wsbn;
        rtw_en        = rtw;
        w             = exp_wait(region, cfg, edfn, wsbn);
        e.wr          = wr && !cfg;
        e.slen        = (rtw && stall > w + 1) ? stall : w + 1;
        e.flt         = ((cfg || !edfn) && !e.wr) ? 1 : 0;
        e.tag         = tag;
        exp_q.push_back(e);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (stall > 0) wait_n = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == stall) wait_n = 1'b1;
            if (poke && n == 1) req_valid = 1'b1;
            if (poke && n == 2) req_valid = 1'b0;
        end while (!req_ready);
        wait_n = 1'b1;
    endtask

    // Monitor: measures each bus cycle at the ports and compares.
    bit in_cyc = 1'b0;
    int n_ale, n_rd, n_wr, n_done, n_flt;
    always @(negedge clk) begin
        if (!rst_n) begin
            in_cyc = 1'b0;
        end else if (ale && !in_cyc) begin
            in_cyc = 1'b1;
            n_ale = 1; n_rd = 0; n_wr = 0; n_done = 0; n_flt = 0;
        end else if (in_cyc) begin
            if (ale)         n_ale++;
            if (!rd_n)       n_rd++;
            if (!wr_n)       n_wr++;
            if (done)        n_done++;
            if (phase == 4)  n_flt++;
            if (phase == 0) begin
                in_cyc = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected bus cycle", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(n_ale == 1, "R2", "ale clocks", n_ale, 1);
                    chk((e.wr ? n_wr : n_rd) == e.slen, e.tag, "strobe length",
                        e.wr ? n_wr : n_rd, e.slen);
                    chk((e.wr ? n_rd : n_wr) == 0, "R3", "wrong strobe clocks",
                        e.wr ? n_rd : n_wr, 0);
                    chk(n_done == 1, "R9", "done clocks", n_done, 1);
                    chk(n_flt == e.flt, "R10", "float clocks", n_flt, e.flt);
                end
            end
        end
    end

    initial begin
        fork
            begin : main_seq
                // R1 reset values
                repeat (3) @(negedge clk);
                chk(req_ready && !ale && rd_n && wr_n && !done && phase == 0 && !wclk,
                    "R1", "outputs in reset", {req_ready, ale, rd_n, wr_n, done, wclk}, 6'b101100);
                rst_n = 1'b1;
                @(negedge clk);
                chk(req_ready && !ale && rd_n && wr_n && !done && phase == 0 && !wclk,
                    "R1", "outputs after reset", {req_ready, ale, rd_n, wr_n, done, wclk}, 6'b101100);

                // R6: other regions take no wait states
                run_acc(2'd0, 1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 0, 1'b0, "R6");
                run_acc(2'd2, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 0, 1'b0, "R6");
                run_acc(2'd3, 1'b0, 1'b0, 1'b0, 2'b01, 1'b0, 0, 1'b0, "R6");
                // R4: standard timing table
                for (int c = 3; c >= 0; c--)
                    run_acc(2'd1, 1'b0, 1'b0, 1'b1, 2'(c), 1'b0, 0, 1'b0, "R4");
                run_acc(2'd1, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 0, 1'b0, "R4");
                // R5: extended timing table, reads show the float clock (R10)
                for (int c = 3; c >= 0; c--)
                    run_acc(2'd1, 1'b0, 1'b0, 1'b0, 2'(c), 1'b0, 0, 1'b0, "R5");
                // R10: extended-timing writes have no float clock
                run_acc(2'd1, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 0, 1'b0, "R5");
                run_acc(2'd1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 0, 1'b0, "R5");
                // R7: configuration fetch forces extended timing and a read
                run_acc(2'd1, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 0, 1'b0, "R7");
                run_acc(2'd1, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 0, 1'b0, "R7");
                run_acc(2'd0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 0, 1'b0, "R7");
                // R8: real-time wait
                run_acc(2'd0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b1, 5, 1'b0, "R8");
                run_acc(2'd1, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 2, 1'b0, "R8");
                run_acc(2'd1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1, 6, 1'b0, "R8");
                run_acc(2'd0, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 6, 1'b0, "R8");
                // R11: request during a busy cycle is dropped
                run_acc(2'd1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 0, 1'b1, "R11");
                repeat (4) begin
                    @(negedge clk);
                    chk(!ale && phase == 0, "R11", "idle after dropped request", phase, 0);
                end
                chk(exp_q.size() == 0, "R11", "pending expected cycles", exp_q.size(), 0);

                // R12: wait clock
                @(negedge clk);
                wclk_en = 1'b1;
                @(negedge clk);
                for (int i = 0; i < 6; i++) begin
                    logic prev;
                    prev = wclk;
                    @(negedge clk);
                    chk(wclk != prev, "R12", "wclk toggle", wclk, !prev);
                end
                wclk_en = 1'b0;
                for (int i = 0; i < 3; i++) begin
                    @(negedge clk);
                    chk(wclk == 1'b0, "R12", "wclk off", wclk, 0);
                end
            end
            begin : watchdog
                repeat (100000) @(posedge clk);
                chk(1'b0, "R1", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule